// File: doc/BRIEF.md
# Tape Record Space Counter

This block governs a space-records operation on a tape drive. Software first writes the frame counter with the two's complement of the number of records to skip over, then pulses a start strobe. While the operation runs, the drive sends one pulse for each record that passes the head. The counter steps upward by one on each of these pulses, and the operation ends when the counter wraps to zero.

The operation also ends when the drive reports a tape mark. The block tells apart three ways an operation can finish. The count can run out. A single tape mark means the end of a file. A tape mark that follows another tape mark, with no record in between, means the logical end of the recorded tape. The history of consecutive marks carries from one operation to the next, so a second space command that meets a mark right away reports end of tape.

On each termination the busy flag drops and a one-cycle done pulse appears with a reason code. The code stays readable until the next termination. Motor and head control sit outside this block.

Top module: `rec_skip_ctl`

## Requirements
- R1: After a synchronous reset, busy is 0, done is 0, reason is 2'b00, the count output is 0 and the tape-mark history is clear.
- R2: A counter write while idle loads the value, and it shows on the count output after the clock edge. A counter write while busy is ignored.
- R3: A start pulse while idle with a nonzero count raises busy after the clock edge. A start pulse while busy has no effect.
- R4: While busy, each record pulse adds one to the count. When the addition wraps the count to zero, busy falls and done pulses with reason 2'b01 (count exhausted). A loaded value of -N therefore ends after exactly N records.
- R5: A start pulse while idle with a count of zero produces a done pulse with reason 2'b01 after the clock edge, and busy stays low.
- R6: A tape-mark pulse while busy, when the last accepted event was not a mark, ends the operation with reason 2'b10 (end of file) and leaves the count unchanged.
- R7: A tape-mark pulse while busy, when the last accepted event since reset was also a mark (in this or an earlier operation), ends the operation with reason 2'b11 (end of tape). An accepted record pulse clears this history.
- R8: When a record pulse and a tape-mark pulse arrive in the same cycle while busy, the mark wins. The record is not counted and does not clear the mark history.
- R9: Record and tape-mark pulses while idle change neither the count, done, nor the mark history.
- R10: Done lasts one cycle per termination. The reason code holds its value until the next termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Frame counter write strobe |
| cnt_wr_data | input | 16 | Value to load (two's complement of record count) |
| go | input | 1 | Start strobe |
| rec_pulse | input | 1 | One-cycle pulse per record passed |
| mark_pulse | input | 1 | One-cycle pulse per tape mark detected |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle termination pulse |
| reason | output | 2 | Termination cause: 01 count, 10 file, 11 end of tape |
| count_q | output | 16 | Current frame counter value |

## Verification
Assertions check several rules on every cycle. The count steps by exactly one on each accepted record. A falling busy always comes with done. A start on a zero count ends at once with the count reason. A mark after a record gives the file reason, and an accepted record clears the mark history. The reason code stays stable between terminations. Other behaviour spans many cycles and shows only in the bench scenarios: a sweep of loaded values shows that exactly N records end the operation. The same goes for mark history carried across operations, the priority of a mark over a simultaneous record, and the discarding of writes, starts and pulses that arrive in the wrong state.

// File: rtl/rec_skip_pkg.sv
package rec_skip_pkg;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'b00,
        RSN_COUNT = 2'b01,
        RSN_FILE  = 2'b10,
        RSN_EOT   = 2'b11
    } stop_reason_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Drive events after qualification by the run state
    typedef struct packed {
        logic rec;
        logic mark;
    } tape_ev_t;

    // Reason for a mark-terminated run given the mark history
    function automatic stop_reason_e mark_reason(input logic prev_mark);
        return prev_mark ? RSN_EOT : RSN_FILE;
    endfunction

endpackage

// File: rtl/rec_skip_counter.sv
module rec_skip_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] q,
    output logic             at_zero,
    output logic             wrap_next
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc) begin
            q <= q + ONE;
        end
    end

    always_comb begin
        at_zero   = (q == '0);
        wrap_next = inc && (q == ALL_ONES);
    end

    a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
        inc |=> (q == $past(q) + ONE));

    a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(load_val)));

    a_r2_load_not_during_count: assert property (@(posedge clk) disable iff (rst)
        !(load && inc));

endmodule

// File: rtl/rec_skip_markdet.sv
module rec_skip_markdet (
    input  logic clk,
    input  logic rst,
    input  logic set_mark,
    input  logic clr_mark,
    output logic seen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
        end else if (set_mark) begin
            seen <= 1'b1;
        end else if (clr_mark) begin
            seen <= 1'b0;
        end
    end

    a_r7_record_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_mark && !set_mark) |=> !seen);

    a_r7_mark_sets: assert property (@(posedge clk) disable iff (rst)
        set_mark |=> seen);

endmodule

// File: rtl/rec_skip_fsm.sv
module rec_skip_fsm
    import rec_skip_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         rec_in,
    input  logic         mark_in,
    input  logic         at_zero,
    input  logic         wrap_next,
    input  logic         seen,
    output tape_ev_t     acc,
    output logic         busy,
    output logic         done,
    output stop_reason_e reason
);
    run_state_e   state, state_n;
    logic         done_n;
    stop_reason_e reason_n;

    always_comb begin
        acc.mark = (state == ST_RUN) && mark_in;
        acc.rec  = (state == ST_RUN) && rec_in && !mark_in;
    end

    always_comb begin
        state_n  = state;
        done_n   = 1'b0;
        reason_n = reason;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    if (at_zero) begin
                        done_n   = 1'b1;
                        reason_n = RSN_COUNT;
                    end else begin
                        state_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (acc.mark) begin
                    state_n  = ST_IDLE;
                    done_n   = 1'b1;
                    reason_n = mark_reason(seen);
                end else if (wrap_next) begin
                    state_n  = ST_IDLE;
                    done_n   = 1'b1;
                    reason_n = RSN_COUNT;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            reason <= RSN_NONE;
        end else begin
            state  <= state_n;
            done   <= done_n;
            reason <= reason_n;
        end
    end

    assign busy = (state == ST_RUN);

    a_r4_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r5_zero_start: assert property (@(posedge clk) disable iff (rst)
        (go && !busy && at_zero) |=> (done && !busy && reason == RSN_COUNT));

    a_r6_single_mark: assert property (@(posedge clk) disable iff (rst)
        (acc.mark && !seen) |=> (done && !busy && reason == RSN_FILE));

    a_r7_double_mark: assert property (@(posedge clk) disable iff (rst)
        (acc.mark && seen) |=> (done && !busy && reason == RSN_EOT));

    a_r10_reason_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(reason));

endmodule

// File: rtl/rec_skip_ctl.sv
module rec_skip_ctl
    import rec_skip_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             go,
    input  logic             rec_pulse,
    input  logic             mark_pulse,
    output logic             busy,
    output logic             done,
    output logic [1:0]       reason,
    output logic [CNT_W-1:0] count_q
);
    tape_ev_t     acc;
    logic         at_zero;
    logic         wrap_next;
    logic         seen;
    logic         load;
    stop_reason_e reason_e;

    assign load = cnt_wr_en && !busy;

    rec_skip_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (cnt_wr_data),
        .inc       (acc.rec),
        .q         (count_q),
        .at_zero   (at_zero),
        .wrap_next (wrap_next)
    );

    rec_skip_markdet u_mark (
        .clk      (clk),
        .rst      (rst),
        .set_mark (acc.mark),
        .clr_mark (acc.rec),
        .seen     (seen)
    );

    rec_skip_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .rec_in    (rec_pulse),
        .mark_in   (mark_pulse),
        .at_zero   (at_zero),
        .wrap_next (wrap_next),
        .seen      (seen),
        .acc       (acc),
        .busy      (busy),
        .done      (done),
        .reason    (reason_e)
    );

    assign reason = reason_e;

    a_r9_idle_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cnt_wr_en) |=> $stable(count_q));

endmodule

// File: tb/rec_skip_ctl_bench.sv
module rec_skip_ctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic        go = 1'b0;
    logic        rec_pulse = 1'b0;
    logic        mark_pulse = 1'b0;
    logic        busy;
    logic        done;
    logic [1:0]  reason;
    logic [15:0] count_q;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [1:0] RC_COUNT = 2'b01;
    localparam logic [1:0] RC_FILE  = 2'b10;
    localparam logic [1:0] RC_EOT   = 2'b11;

    always #10 clk = ~clk;

    rec_skip_ctl u_rec_skip_ctl (
        .clk (clk), .rst (rst), .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
        .go (go), .rec_pulse (rec_pulse), .mark_pulse (mark_pulse),
        .busy (busy), .done (done), .reason (reason), .count_q (count_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs from a falling edge; returns at the next falling edge
    task automatic step(input bit w, input logic [15:0] wd, input bit g, input bit r, input bit m);
        cnt_wr_en = w; cnt_wr_data = wd; go = g; rec_pulse = r; mark_pulse = m;
        @(negedge clk);
        cnt_wr_en = 0; go = 0; rec_pulse = 0; mark_pulse = 0;
    endtask

    // status packed as {busy, done, reason}
    function automatic logic [3:0] st();
        return {busy, done, reason};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(st() == 4'b0000 && count_q == 16'h0, "R1 reset status", {st(), count_q}, 32'h0);

        // R4 / R5 sweep of loaded counts
        for (int n = 0; n <= 40; n++) begin
            step(1, 16'(-n), 0, 0, 0);
            chk(count_q == 16'(-n), "R2 idle load", count_q, 16'(-n));
            step(0, 0, 1, 0, 0);
            if (n == 0)
                chk(st() == {2'b01, RC_COUNT}, "R5 zero start", st(), {2'b01, RC_COUNT});
            else
                chk(busy && !done, "R3 start busy", st(), 4'b1000);
            for (int k = 1; k <= n; k++) begin
                step(0, 0, 0, 1, 0);
                if (k < n)
                    chk(busy && !done && count_q == 16'(k - n), "R4 counting",
                        {st(), count_q}, {4'b1000, 16'(k - n)});
                else
                    chk(st() == {2'b01, RC_COUNT} && count_q == 16'h0, "R4 count end",
                        {st(), count_q}, {2'b01, RC_COUNT, 16'h0});
            end
            step(0, 0, 0, 0, 0);
            chk(st() == {2'b00, RC_COUNT}, "R10 pulse and hold", st(), {2'b00, RC_COUNT});
        end

        // R6 single mark after records
        step(1, 16'hFFFB, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        chk(st() == {2'b01, RC_FILE} && count_q == 16'hFFFD, "R6 file mark",
            {st(), count_q}, {2'b01, RC_FILE, 16'hFFFD});
        step(0, 0, 0, 0, 0);
        chk(st() == {2'b00, RC_FILE}, "R10 reason held", st(), {2'b00, RC_FILE});

        // R7 mark first in next run -> end of tape
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1);
        chk(st() == {2'b01, RC_EOT} && count_q == 16'hFFFD, "R7 end of tape",
            {st(), count_q}, {2'b01, RC_EOT, 16'hFFFD});

        // R7 record between marks clears history
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        chk(st() == {2'b01, RC_FILE} && count_q == 16'hFFFE, "R7 history cleared",
            {st(), count_q}, {2'b01, RC_FILE, 16'hFFFE});

        // R8 simultaneous record and mark: mark wins, history kept
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1);
        chk(st() == {2'b01, RC_EOT} && count_q == 16'hFFFE, "R8 mark priority",
            {st(), count_q}, {2'b01, RC_EOT, 16'hFFFE});

        // R9 idle pulses ignored
        step(0, 0, 0, 1, 0);
        chk(!done && count_q == 16'hFFFE, "R9 idle record", {st(), count_q}, {4'b0011, 16'hFFFE});
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        chk(st() == {2'b01, RC_COUNT} && count_q == 16'h0, "R4 run after marks",
            {st(), count_q}, {2'b01, RC_COUNT, 16'h0});
        step(0, 0, 0, 0, 1);
        chk(!done && count_q == 16'h0, "R9 idle mark", {st(), count_q}, {4'b0001, 16'h0});
        step(1, 16'hFFFE, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1);
        chk(st() == {2'b01, RC_FILE}, "R9 idle mark left no history", st(), {2'b01, RC_FILE});

        // R2 / R3 writes and starts while busy are ignored
        step(1, 16'hFFFD, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(1, 16'h1234, 0, 0, 0);
        chk(busy && count_q == 16'hFFFD, "R2 busy write ignored", count_q, 16'hFFFD);
        step(0, 0, 1, 0, 0);
        chk(busy && !done && count_q == 16'hFFFD, "R3 busy start ignored",
            {st(), count_q}, {4'b1000, 16'hFFFD});
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0);
        chk(st() == {2'b01, RC_COUNT} && count_q == 16'h0, "R4 three records",
            {st(), count_q}, {2'b01, RC_COUNT, 16'h0});

        // R4 long run
        step(1, 16'(-1000), 0, 0, 0);
        step(0, 0, 1, 0, 0);
        for (int k = 1; k < 1000; k++) step(0, 0, 0, 1, 0);
        chk(busy && count_q == 16'hFFFF, "R4 long run before end", {st(), count_q}, {4'b1001, 16'hFFFF});
        step(0, 0, 0, 1, 0);
        chk(st() == {2'b01, RC_COUNT} && count_q == 16'h0, "R4 long run end",
            {st(), count_q}, {2'b01, RC_COUNT, 16'h0});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule